// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous requester and an external asynchronous static RAM. The RAM has two chip selects, one active low and one active high, plus an active-low output enable and an active-low write enable. A requester presents a single read or write. The controller drives the address, the strobes and the direction of the data bus. It counts system clock cycles so that each timing limit of the chosen speed grade is met, and it returns read data with a one-cycle done pulse.

All timing is derived at elaboration time from the clock period in nanoseconds and a speed-grade parameter. Each limit is converted to cycles by rounding up. A write is ended by raising the write enable while both chip selects stay active, so the data hold time is referenced to that one edge. After a read, the controller waits for the RAM's output driver to float before it drives the bus again.

A level request moves the idle controller into a deselected low-power retention state. When that request is withdrawn, no access starts until one full read-cycle time has passed.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and right after reset, mem_sel_n=1, mem_sel=0, mem_out_en_n=1, mem_wr_n=1, mem_drive=0, and busy, done and in_retention are 0.
- R2: A read holds mem_sel_n=0, mem_sel=1 and mem_out_en_n=0, with mem_drive=0 and a stable address, for RD_CYC cycles. RD_CYC is the rounded-up maximum of read cycle time, address access and output-enable access: 55/55/25 ns, or 70/70/35 ns when SLOW_GRADE=1, giving 11 cycles at 5 ns. The data present at the end is returned on rd_data, and done is high for exactly one cycle.
- R3: A write holds mem_wr_n=0 for WE_CYC cycles while both selects are active, mem_out_en_n=1 and mem_drive=1. WE_CYC is the rounded-up select-to-write-end time of 45 ns (60 ns slow), giving 9 cycles at 5 ns.
- R4: A write ends when mem_wr_n rises while both selects are still active. Address and write data stay driven for one more cycle, and done pulses for one cycle after that.
- R5: busy lasts RD_CYC+FL_CYC cycles for a read. For a write it lasts WE_CYC+1+PAD_CYC cycles, where PAD_CYC=max(ceil(55 ns or 70 ns)-WE_CYC-1,1). This makes a write at least one write-cycle time long (11 cycles at default).
- R6: After mem_out_en_n rises at the end of a read, mem_drive stays 0 for at least FL_CYC cycles. FL_CYC is the rounded-up bus float time of 20 ns (25 ns slow), giving 4 cycles at default.
- R7: A request is accepted only from idle with ret_req low. busy rises in the cycle after acceptance. A request held high while busy is taken only after the current access has ended.
- R8: ret_req has priority over req_valid in idle. While ret_req stays high, the controller sits deselected with mem_sel_n=1, mem_sel=0, in_retention=1 and busy=0, and starts no pending request.
- R9: After ret_req falls, no access starts before RCV_CYC cycles, the rounded-up read-cycle time (11 cycles at default), and busy is high for that recovery interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, held until busy rises |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| ret_req | input | 1 | Level request for the retention state |
| busy | output | 1 | Access or recovery in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| in_retention | output | 1 | Controller is in the retention state |
| mem_addr | output | ADDR_W | RAM address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_out_en_n | output | 1 | Active-low RAM output enable |
| mem_wr_n | output | 1 | Active-low RAM write enable |
| mem_wdata | output | DATA_W | Data driven to the RAM |
| mem_drive | output | 1 | 1 = controller drives the data bus |
| mem_rdata | input | DATA_W | Data from the RAM bus |

## Verification
A wrong state or a wrong timer load shows at the pins within one access. A strobe-low run is shorter or longer than its cycle count, busy has the wrong length, or a pulse lands one cycle early or late. A state that enables the RAM output while driving, or that drops a select before the write enable, shows in the same cycle as a bus fight or an unqualified write edge. A faulty retention exit shows as an access that starts before the recovery count has elapsed.

// File: rtl/sram_seq_ctrl_pkg.sv
package sram_seq_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WR,
      ST_WR_HOLD,
      ST_WR_PAD,
      ST_FLOAT,
      ST_RET,
      ST_RECOVER
   } ctrl_state_t;

   typedef struct packed {
      logic sel_n;
      logic sel;
      logic out_en_n;
      logic wr_n;
      logic drive;
   } strobe_t;

   // nanoseconds to whole clock cycles, rounded up
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/sram_strobe_decode.sv
module sram_strobe_decode
   import sram_seq_ctrl_pkg::*;
(
   input  ctrl_state_t st,
   output strobe_t     stb
);
   always_comb begin
      stb = '{sel_n: 1'b1, sel: 1'b0, out_en_n: 1'b1, wr_n: 1'b1, drive: 1'b0};
      case (st)
         ST_RD: begin
            stb.sel_n    = 1'b0;
            stb.sel      = 1'b1;
            stb.out_en_n = 1'b0;
         end
         ST_WR: begin
            stb.sel_n = 1'b0;
            stb.sel   = 1'b1;
            stb.wr_n  = 1'b0;
            stb.drive = 1'b1;
         end
         ST_WR_HOLD: begin
            stb.sel_n = 1'b0;
            stb.sel   = 1'b1;
            stb.drive = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_rd,
   input  logic              wr_fin,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         done    <= 1'b0;
      end else begin
         done <= cap_rd | wr_fin;
         if (cap_rd) rd_data <= bus_in;
      end
   end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 18,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 5,
   parameter bit SLOW_GRADE    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ret_req,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              in_retention,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_sel,
   output logic              mem_out_en_n,
   output logic              mem_wr_n,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_drive,
   input  logic [DATA_W-1:0] mem_rdata
);
   // speed-grade limits in ns
   localparam int CYC_NS   = SLOW_GRADE ? 70 : 55;
   localparam int ACC_NS   = SLOW_GRADE ? 70 : 55;
   localparam int OEACC_NS = SLOW_GRADE ? 35 : 25;
   localparam int SELWE_NS = SLOW_GRADE ? 60 : 45;
   localparam int FLOAT_NS = SLOW_GRADE ? 25 : 20;

   localparam int RD_CYC  = ns_to_cyc(imax(CYC_NS, imax(ACC_NS, OEACC_NS)), CLK_PERIOD_NS);
   localparam int WE_CYC  = ns_to_cyc(SELWE_NS, CLK_PERIOD_NS);
   localparam int WC_CYC  = ns_to_cyc(CYC_NS, CLK_PERIOD_NS);
   localparam int FL_CYC  = imax(ns_to_cyc(FLOAT_NS, CLK_PERIOD_NS), 1);
   localparam int PAD_CYC = imax(WC_CYC - WE_CYC - 1, 1);
   localparam int RCV_CYC = ns_to_cyc(CYC_NS, CLK_PERIOD_NS);
   localparam int MAX_CYC = imax(imax(RD_CYC, WE_CYC), imax(imax(FL_CYC, PAD_CYC), RCV_CYC));
   localparam int TMR_W   = $clog2(MAX_CYC + 1);

   localparam logic [TMR_W-1:0] RD_LD  = TMR_W'(RD_CYC - 1);
   localparam logic [TMR_W-1:0] WE_LD  = TMR_W'(WE_CYC - 1);
   localparam logic [TMR_W-1:0] FL_LD  = TMR_W'(FL_CYC - 1);
   localparam logic [TMR_W-1:0] PAD_LD = TMR_W'(PAD_CYC - 1);
   localparam logic [TMR_W-1:0] RCV_LD = TMR_W'(RCV_CYC - 1);

   // elaboration-time parameter checks
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_seq_ctrl: ADDR_W and DATA_W must be positive");
   end
   if (CLK_PERIOD_NS < 1) begin : g_bad_clk
      $error("sram_seq_ctrl: CLK_PERIOD_NS must be at least 1");
   end
   if (MAX_CYC > 250) begin : g_bad_range
      $error("sram_seq_ctrl: cycle counts exceed the checker range");
   end

   ctrl_state_t       st, st_nxt;
   logic              tmr_load, tmr_zero;
   logic [TMR_W-1:0]  tmr_val;
   logic              cap_rd, wr_fin, accept;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   strobe_t           stb;

   assign accept = (st == ST_IDLE) && !ret_req && req_valid;

   always_comb begin
      st_nxt   = st;
      tmr_load = 1'b0;
      tmr_val  = '0;
      cap_rd   = 1'b0;
      wr_fin   = 1'b0;
      case (st)
         ST_IDLE: begin
            if (ret_req) begin
               st_nxt = ST_RET;
            end else if (req_valid) begin
               st_nxt   = req_write ? ST_WR : ST_RD;
               tmr_load = 1'b1;
               tmr_val  = req_write ? WE_LD : RD_LD;
            end
         end
         ST_RD: if (tmr_zero) begin
            st_nxt   = ST_FLOAT;
            tmr_load = 1'b1;
            tmr_val  = FL_LD;
            cap_rd   = 1'b1;
         end
         ST_FLOAT:   if (tmr_zero) st_nxt = ST_IDLE;
         ST_WR:      if (tmr_zero) st_nxt = ST_WR_HOLD;
         ST_WR_HOLD: begin
            st_nxt   = ST_WR_PAD;
            tmr_load = 1'b1;
            tmr_val  = PAD_LD;
            wr_fin   = 1'b1;
         end
         ST_WR_PAD:  if (tmr_zero) st_nxt = ST_IDLE;
         ST_RET: if (!ret_req) begin
            st_nxt   = ST_RECOVER;
            tmr_load = 1'b1;
            tmr_val  = RCV_LD;
         end
         ST_RECOVER: if (tmr_zero) st_nxt = ST_IDLE;
         default:    st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         st <= st_nxt;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
      end
   end

   sram_cyc_timer #(.W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sram_strobe_decode u_decode (
      .st  (st),
      .stb (stb)
   );

   sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_rd  (cap_rd),
      .wr_fin  (wr_fin),
      .bus_in  (mem_rdata),
      .rd_data (rd_data),
      .done    (done)
   );

   assign busy         = !(st == ST_IDLE || st == ST_RET);
   assign in_retention = (st == ST_RET);
   assign mem_addr     = addr_q;
   assign mem_wdata    = wdata_q;
   assign mem_sel_n    = stb.sel_n;
   assign mem_sel      = stb.sel;
   assign mem_out_en_n = stb.out_en_n;
   assign mem_wr_n     = stb.wr_n;
   assign mem_drive    = stb.drive;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk
   import sram_seq_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 18,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 5,
   parameter bit SLOW_GRADE    = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              in_retention,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_sel_n,
   input logic              mem_sel,
   input logic              mem_out_en_n,
   input logic              mem_wr_n,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_drive
);
   localparam int FL_MIN  = imax(ns_to_cyc(SLOW_GRADE ? 25 : 20, CLK_PERIOD_NS), 1);
   localparam int RCV_MIN = ns_to_cyc(SLOW_GRADE ? 70 : 55, CLK_PERIOD_NS);

   logic [7:0] since_oe, since_ret;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_oe  <= 8'hFF;
         since_ret <= 8'hFF;
      end else begin
         if (!mem_out_en_n)         since_oe <= 8'd0;
         else if (since_oe != 8'hFF) since_oe <= since_oe + 8'd1;
         if (in_retention)           since_ret <= 8'd0;
         else if (since_ret != 8'hFF) since_ret <= since_ret + 8'd1;
      end
   end

   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_out_en_n |-> !mem_drive);  // R2
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));  // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R2
   AST_WR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n |-> (!mem_sel_n && mem_sel && mem_out_en_n && mem_drive));  // R3
   AST_WR_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_n) |-> (!mem_sel_n && mem_sel && mem_drive && $stable(mem_addr) && $stable(mem_wdata)));  // R4
   AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_drive) |-> (int'(since_oe) >= FL_MIN));  // R6
   AST_RET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      in_retention |-> (mem_sel_n && !mem_sel && !busy));  // R8
   AST_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_sel_n) |-> (int'(since_ret) >= RCV_MIN));  // R9
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .CLK_PERIOD_NS(CLK_PERIOD_NS), .SLOW_GRADE(SLOW_GRADE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .in_retention(in_retention), .mem_addr(mem_addr),
   .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_out_en_n(mem_out_en_n),
   .mem_wr_n(mem_wr_n), .mem_wdata(mem_wdata), .mem_drive(mem_drive)
);

// File: tb/sram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sram_seq_ctrl_test;
   localparam int AW = 18;
   localparam int DW = 8;
   localparam int CLK_NS = 5;

   // expected cycle counts, fast grade at 5 ns
   localparam int E_RD  = (55 + CLK_NS - 1) / CLK_NS;   // 11
   localparam int E_WE  = (45 + CLK_NS - 1) / CLK_NS;   // 9
   localparam int E_FL  = (20 + CLK_NS - 1) / CLK_NS;   // 4
   localparam int E_WC  = (55 + CLK_NS - 1) / CLK_NS;   // 11
   localparam int E_PAD = (E_WC - E_WE - 1 > 1) ? E_WC - E_WE - 1 : 1;
   localparam int E_RCV = E_WC;

   typedef struct packed {
      logic       wr;
      logic [7:0] addr;
      logic [7:0] data;
   } vec_t;

   localparam vec_t VECS [0:7] = '{
      '{1'b1, 8'h05, 8'hA5},
      '{1'b1, 8'h3A, 8'h5C},
      '{1'b1, 8'hFF, 8'h01},
      '{1'b0, 8'h05, 8'hA5},
      '{1'b0, 8'h3A, 8'h5C},
      '{1'b1, 8'h05, 8'h00},
      '{1'b0, 8'h05, 8'h00},
      '{1'b0, 8'hFF, 8'h01}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, ret_req = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic busy, done, in_retention, mem_sel_n, mem_sel, mem_out_en_n, mem_wr_n, mem_drive;
   logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
   logic [AW-1:0] mem_addr;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #(CLK_NS / 2.0) clk = ~clk;

   sram_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .ret_req(ret_req),
      .busy(busy), .done(done), .rd_data(rd_data), .in_retention(in_retention),
      .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
      .mem_out_en_n(mem_out_en_n), .mem_wr_n(mem_wr_n), .mem_wdata(mem_wdata),
      .mem_drive(mem_drive), .mem_rdata(mem_rdata)
   );

   // RAM model: write at the rising write enable, read while selected and enabled
   logic [7:0] mem [0:255];
   initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
   always @(posedge mem_wr_n) if (mem_sel_n === 1'b0 && mem_sel === 1'b1) mem[mem_addr[7:0]] = mem_wdata;
   assign mem_rdata = (!mem_sel_n && mem_sel && !mem_out_en_n) ? mem[mem_addr[7:0]] : 8'h00;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // strobe monitor
   int we_run = 0, we_len = 0, oe_run = 0, oe_len = 0, gap_run = 0, gap_len = -1;
   bit gap_arm = 0;
   always @(negedge clk) begin
      cyc++;
      if (!mem_wr_n) we_run++;
      else if (we_run != 0) begin
         we_len = we_run;
         we_run = 0;
         check("R4 selects held and bus driven after write end",
               int'(!mem_sel_n && mem_sel && mem_drive), 1);
      end
      if (!mem_out_en_n) oe_run++;
      else if (oe_run != 0) begin oe_len = oe_run; oe_run = 0; end
      if (!mem_out_en_n) begin gap_run = 0; gap_arm = 1; end
      else if (gap_arm && !mem_drive) gap_run++;
      else if (gap_arm && mem_drive) begin gap_len = gap_run; gap_arm = 0; end
   end

   always @(negedge clk) if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic run_op(input logic wr, input logic [7:0] a, input logic [7:0] d,
                         output int bcyc, output int ndone, output logic [7:0] rdv);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = {10'd0, a}; req_wdata = d;
      @(negedge clk);
      while (!busy) @(negedge clk);
      req_valid = 1'b0;
      bcyc = 0; ndone = 0; rdv = 8'h00;
      while (busy) begin
         bcyc++;
         if (done) begin ndone++; rdv = rd_data; end
         @(negedge clk);
      end
   endtask

   initial begin
      int bc, nd, n;
      logic [7:0] rv;

      // R1 reset state
      #12;
      check("R1 reset strobes", int'({mem_sel_n, mem_sel, mem_out_en_n, mem_wr_n, mem_drive}), 5'b10110);
      check("R1 reset flags", int'({busy, done, in_retention}), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset strobes", int'({mem_sel_n, mem_sel, mem_out_en_n, mem_wr_n, mem_drive}), 5'b10110);

      // vector table
      for (int i = 0; i < 8; i++) begin
         run_op(VECS[i].wr, VECS[i].addr, VECS[i].data, bc, nd, rv);
         check("R2 R4 single done pulse", nd, 1);
         if (VECS[i].wr) begin
            check("R5 write busy length", bc, E_WE + 1 + E_PAD);
            check("R3 write enable low cycles", we_len, E_WE);
         end else begin
            check("R5 read busy length", bc, E_RD + E_FL);
            check("R2 output enable low cycles", oe_len, E_RD);
            check("R2 read data", int'(rv), int'(VECS[i].data));
         end
      end

      // R7 + R6: write request held during a read, taken after it ends
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = {10'd0, 8'h3A};
      @(negedge clk);
      while (!busy) @(negedge clk);
      req_write = 1'b1; req_addr = {10'd0, 8'h77}; req_wdata = 8'hC3;
      n = 0;
      while (busy) begin
         check("R7 no write strobe while read busy", int'(mem_wr_n), 1);
         if (done) check("R2 read data with pending write", int'(rd_data), 8'h5C);
         n++;
         @(negedge clk);
      end
      check("R7 first access busy length", n, E_RD + E_FL);
      while (!busy) @(negedge clk);
      req_valid = 1'b0;
      while (busy) @(negedge clk);
      check("R6 float gap before drive", int'(gap_len >= E_FL), 1);
      check("R7 held write landed", int'(mem[8'h77]), 8'hC3);

      // R8 retention entry has priority, requests held
      @(negedge clk);
      ret_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = {10'd0, 8'h3A};
      repeat (6) @(negedge clk);
      check("R8 in retention", int'(in_retention), 1);
      check("R8 deselected", int'({mem_sel_n, mem_sel}), 2'b10);
      check("R8 busy low and no access", int'({busy, mem_out_en_n}), 2'b01);

      // R9 recovery interval
      ret_req = 1'b0;
      n = 0;
      do begin @(negedge clk); n++; end while (mem_sel_n && n < 100);
      check("R9 recovery not shorter", int'(n >= E_RCV), 1);
      check("R9 recovery not excessive", int'(n <= E_RCV + 3), 1);
      req_valid = 1'b0;
      n = 0;
      while (!done && n < 100) begin @(negedge clk); n++; end
      check("R9 read after recovery", int'(rd_data), 8'h5C);
      check("R8 retention left", int'(in_retention), 0);

      repeat (8) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule